// File: doc/BRIEF.md
# Warning-Bit Instruction Extractor

This block sits after instruction fetch in the variable-length code mode. Fetch delivers aligned 256-bit lines made of eight 32-bit words. The block emits one instruction per cycle in rising word order. Each instruction is either a single 32-bit word or a 64-bit pair of adjacent words. The words do not encode their own length. Instead, the top bit of every word is a warning flag that concerns the *next* sequential line. A flag at slot i means slot i of the following line opens a 64-bit instruction, and slot i+1 of that same line completes it.

The block holds one line at a time. It keeps the warning flags of the line it is consuming and hands them on to the line that follows. It accepts a new line in the same cycle the last instruction of the old one is taken. A redirect (taken branch) throws away the held line and any carried flags. The next line then starts at the word offset the redirect carries, with no inherited flags. Words in front of the offset are skipped, so any 64-bit instruction in the target line sits wholly before the target word. The block marks two illegal encodings on the instruction concerned: a flag in the last slot of a line, and a flag that lands on the second half of a 64-bit instruction. Paired register-to-register words pass through as plain 32-bit units.

Top module: `wbx_extract`

## Requirements
- R1: While reset is high and in the first cycle after it, `ins_valid` is 0. After reset `line_ready` is 1, and the first line inherits no warning flags.
- R2: Word i of `line_data` is bits [32*i+31:32*i]. In a line with no inherited flags, every word at or after the start slot is emitted as its own 32-bit instruction in ascending slot order. For such an instruction `ins_wide`=0, `ins_data[63:32]` is the word, `ins_data[31:0]` is 0, and `ins_addr` = {line address, 3-bit slot}.
- R3: Bit 31 of word i in a line marks slot i of the next sequential line. When that slot is reached, words i and i+1 leave as one instruction with `ins_wide`=1, `ins_data` = {word i, word i+1}, and the address of slot i. Emission then continues at slot i+2.
- R4: The flags of a line apply only to the line accepted directly after it, never to a later one.
- R5: A flag set in slot 7 of a line raises `ins_err` on the instruction that covers slot 7 of that same line. It is not carried on, so slot 7 of the next line is 32-bit.
- R6: Suppose an inherited flag marks a slot that is already the second half of a 64-bit instruction. Then `ins_err` is 1 on that 64-bit instruction, and the slot does not open a new instruction.
- R7: A cycle with `redir_valid`=1 has `ins_valid`=0 and `line_ready`=0, and it discards the held line and the carried flags. The next accepted line starts at `redir_off`, with no inherited flags. Nothing of the discarded line is emitted afterwards.
- R8: While `ins_valid`=1 and `ins_ready`=0 (and no redirect), the offered instruction stays unchanged. Stalls change only timing, never the sequence of instructions.
- R9: A new line is accepted in the same cycle the last instruction of the held line is taken. With `ins_ready` held high, consecutive lines emit one instruction per cycle without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_valid | input | 1 | A fetched line is offered |
| line_ready | output | 1 | The block takes the offered line |
| line_data | input | 256 | Eight 32-bit words, word 0 in the low bits |
| line_addr | input | 16 | Line address of the offered line |
| redir_valid | input | 1 | Taken branch: flush and restart |
| redir_off | input | 3 | Target word slot in the next accepted line |
| ins_valid | output | 1 | An instruction is offered |
| ins_ready | input | 1 | Consumer takes the instruction |
| ins_data | output | 64 | First word in the high half, second word or zero in the low half |
| ins_wide | output | 1 | 1 for a 64-bit instruction |
| ins_addr | output | 19 | Word address of the first word |
| ins_err | output | 1 | Illegal warning-flag placement on this instruction |

## Verification
Flag-free lines show plain 32-bit slicing, address formation and gap-free streaming across a line change. A three-line run with scattered flags shows that flags move exactly one line forward and no further. Flags in slot 7 and on adjacent slots separate the two error cases from legal pairing. A redirect after a fully flagged line, and a redirect while an instruction is stalled, show that carried flags and the held line are dropped and that the words in front of the target are skipped. Running the mixed case again with a toggling ready shows that stalls leave the sequence unchanged.

// File: rtl/wbx_pkg.sv
package wbx_pkg;

    localparam int DEF_WW = 32;
    localparam int DEF_NW = 8;
    localparam int DEF_AW = 16;

    typedef struct packed {
        logic wide;
        logic err;
        logic last;
    } pick_t;

endpackage

// File: rtl/wbx_slot_pick.sv
module wbx_slot_pick
    import wbx_pkg::*;
#(
    parameter int NW = DEF_NW,
    localparam int PW = $clog2(NW)
) (
    input  logic [PW-1:0] ptr,
    input  logic [NW-1:0] inh,
    input  logic          flag_top,
    output pick_t         info,
    output logic [PW:0]   nxt
);
    logic [PW-1:0] ptr1;
    logic          wide;

    always_comb begin
        ptr1 = ptr + PW'(1);
        wide = inh[ptr] && (ptr != PW'(NW - 1));
        nxt  = {1'b0, ptr} + (wide ? (PW+1)'(2) : (PW+1)'(1));
        info.wide = wide;
        info.last = (nxt >= (PW+1)'(NW));
        info.err  = (wide && inh[ptr1]) || (info.last && flag_top);
    end
endmodule

// File: rtl/wbx_word_sel.sv
module wbx_word_sel
    import wbx_pkg::*;
#(
    parameter int NW = DEF_NW,
    parameter int WW = DEF_WW,
    localparam int PW = $clog2(NW)
) (
    input  logic [NW*WW-1:0] line_q,
    input  logic [PW-1:0]    ptr,
    input  logic             wide,
    output logic [2*WW-1:0]  data
);
    logic [WW-1:0] words [NW];
    logic [PW-1:0] ptr1;

    for (genvar i = 0; i < NW; i++) begin : g_word
        assign words[i] = line_q[i*WW +: WW];
    end

    always_comb begin
        ptr1 = ptr + PW'(1);
        data = {words[ptr], (wide ? words[ptr1] : {WW{1'b0}})};
    end
endmodule

// File: rtl/wbx_line_hold.sv
module wbx_line_hold
    import wbx_pkg::*;
#(
    parameter int NW = DEF_NW,
    parameter int WW = DEF_WW,
    parameter int AW = DEF_AW,
    localparam int PW = $clog2(NW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic             rel,
    input  logic             adv,
    input  logic             redir,
    input  logic [PW-1:0]    redir_off,
    input  logic [NW*WW-1:0] in_data,
    input  logic [AW-1:0]    in_addr,
    input  logic [PW:0]      nxt,
    output logic             have,
    output logic [NW*WW-1:0] line_q,
    output logic [AW-1:0]    addr_q,
    output logic [NW-1:0]    inh_q,
    output logic [NW-1:0]    flag_q,
    output logic [PW-1:0]    ptr_q
);
    localparam logic [NW-1:0] KEEP = {1'b0, {(NW-1){1'b1}}};

    logic [NW-1:0] flag_in;
    logic [NW-1:0] carry_q;
    logic [PW-1:0] start_q;

    for (genvar i = 0; i < NW; i++) begin : g_flag
        assign flag_in[i] = in_data[i*WW + WW - 1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have    <= 1'b0;
            line_q  <= '0;
            addr_q  <= '0;
            inh_q   <= '0;
            flag_q  <= '0;
            ptr_q   <= '0;
            carry_q <= '0;
            start_q <= '0;
        end else if (redir) begin
            have    <= 1'b0;
            carry_q <= '0;
            start_q <= redir_off;
        end else begin
            if (rel) begin
                have    <= 1'b0;
                carry_q <= flag_q & KEEP;
            end
            if (acc) begin
                have    <= 1'b1;
                line_q  <= in_data;
                addr_q  <= in_addr;
                flag_q  <= flag_in;
                ptr_q   <= start_q;
                start_q <= '0;
                inh_q   <= rel ? (flag_q & KEEP) : carry_q;
            end else if (adv && !rel) begin
                ptr_q <= nxt[PW-1:0];
            end
        end
    end
endmodule

// File: rtl/wbx_extract.sv
module wbx_extract
    import wbx_pkg::*;
#(
    parameter int NW = DEF_NW,
    parameter int WW = DEF_WW,
    parameter int AW = DEF_AW,
    localparam int PW = $clog2(NW)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_valid,
    output logic               line_ready,
    input  logic [NW*WW-1:0]   line_data,
    input  logic [AW-1:0]      line_addr,
    input  logic               redir_valid,
    input  logic [PW-1:0]      redir_off,
    output logic               ins_valid,
    input  logic               ins_ready,
    output logic [2*WW-1:0]    ins_data,
    output logic               ins_wide,
    output logic [AW+PW-1:0]   ins_addr,
    output logic               ins_err
);
    logic             have;
    logic [NW*WW-1:0] line_q;
    logic [AW-1:0]    addr_q;
    logic [NW-1:0]    inh_q;
    logic [NW-1:0]    flag_q;
    logic [PW-1:0]    ptr_q;
    logic [PW:0]      nxt;
    pick_t            info;
    logic             fire;
    logic             rel;
    logic             acc;

    assign ins_valid  = have && !redir_valid;
    assign fire       = ins_valid && ins_ready;
    assign rel        = fire && info.last;
    assign line_ready = !redir_valid && (!have || rel);
    assign acc        = line_valid && line_ready;

    wbx_line_hold #(.NW(NW), .WW(WW), .AW(AW)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .rel       (rel),
        .adv       (fire),
        .redir     (redir_valid),
        .redir_off (redir_off),
        .in_data   (line_data),
        .in_addr   (line_addr),
        .nxt       (nxt),
        .have      (have),
        .line_q    (line_q),
        .addr_q    (addr_q),
        .inh_q     (inh_q),
        .flag_q    (flag_q),
        .ptr_q     (ptr_q)
    );

    wbx_slot_pick #(.NW(NW)) u_pick (
        .ptr      (ptr_q),
        .inh      (inh_q),
        .flag_top (flag_q[NW-1]),
        .info     (info),
        .nxt      (nxt)
    );

    wbx_word_sel #(.NW(NW), .WW(WW)) u_sel (
        .line_q (line_q),
        .ptr    (ptr_q),
        .wide   (info.wide),
        .data   (ins_data)
    );

    assign ins_wide = info.wide;
    assign ins_err  = info.err;
    assign ins_addr = {addr_q, ptr_q};
endmodule

// File: rtl/wbx_chk.sv
module wbx_chk #(
    parameter int NW = 8,
    parameter int WW = 32,
    parameter int AW = 16,
    localparam int PW = $clog2(NW)
) (
    input logic             clk,
    input logic             rst,
    input logic             line_valid,
    input logic             line_ready,
    input logic             redir_valid,
    input logic             ins_valid,
    input logic             ins_ready,
    input logic [2*WW-1:0]  ins_data,
    input logic             ins_wide,
    input logic [AW+PW-1:0] ins_addr
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ins_valid);

    // R7
    redir_block_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (!ins_valid && !line_ready));

    // R7
    redir_flush_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !ins_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_ready && !redir_valid) |=>
        (redir_valid || (ins_valid && $stable(ins_data) && $stable(ins_addr) && $stable(ins_wide))));

    // R3
    wide_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_wide) |-> (ins_addr[PW-1:0] != PW'(NW - 1)));

    // R9
    take_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        (line_valid && line_ready && ins_valid) |-> ins_ready);
endmodule

bind wbx_extract wbx_chk #(.NW(NW), .WW(WW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_valid  (line_valid),
    .line_ready  (line_ready),
    .redir_valid (redir_valid),
    .ins_valid   (ins_valid),
    .ins_ready   (ins_ready),
    .ins_data    (ins_data),
    .ins_wide    (ins_wide),
    .ins_addr    (ins_addr)
);

// File: tb/tb_wbx_extract.sv
module tb_wbx_extract;
    localparam int NW = 8;
    localparam int WW = 32;
    localparam int AW = 16;
    localparam int PW = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               line_valid = 1'b0;
    logic               line_ready;
    logic [NW*WW-1:0]   line_data = '0;
    logic [AW-1:0]      line_addr = '0;
    logic               redir_valid = 1'b0;
    logic [PW-1:0]      redir_off = '0;
    logic               ins_valid;
    logic               ins_ready = 1'b1;
    logic [2*WW-1:0]    ins_data;
    logic               ins_wide;
    logic [AW+PW-1:0]   ins_addr;
    logic               ins_err;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    int stall_mode = 0;
    bit done = 1'b0;

    logic [NW*WW-1:0] seq_data [4];
    logic [AW-1:0]    seq_addr [4];

    logic [63:0]      g_data [64];
    logic             g_wide [64];
    logic [AW+PW-1:0] g_addr [64];
    logic             g_err  [64];
    int               g_cyc  [64];
    int               g_n = 0;

    logic [63:0]      e_data [64];
    logic             e_wide [64];
    logic [AW+PW-1:0] e_addr [64];
    logic             e_err  [64];
    int               e_n = 0;

    wbx_extract #(.NW(NW), .WW(WW), .AW(AW)) dut (
        .clk(clk), .rst(rst),
        .line_valid(line_valid), .line_ready(line_ready),
        .line_data(line_data), .line_addr(line_addr),
        .redir_valid(redir_valid), .redir_off(redir_off),
        .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_data(ins_data), .ins_wide(ins_wide),
        .ins_addr(ins_addr), .ins_err(ins_err)
    );

    always #4 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    initial forever begin
        @(posedge clk);
        #1;
        case (stall_mode)
            0: ins_ready = 1'b1;
            1: ins_ready = (cyc % 3) != 1;
            default: ins_ready = 1'b0;
        endcase
    end

    initial forever begin
        @(negedge clk);
        if (!rst && ins_valid && ins_ready && g_n < 64) begin
            g_data[g_n] = ins_data;
            g_wide[g_n] = ins_wide;
            g_addr[g_n] = ins_addr;
            g_err[g_n]  = ins_err;
            g_cyc[g_n]  = cyc;
            g_n++;
        end
    end

    function automatic logic [31:0] mk_word(int seed, int i, bit w);
        return {w, 7'(seed), 8'(i), 16'(seed * 37 + i * 5 + 3)};
    endfunction

    function automatic logic [NW*WW-1:0] mk_line(int seed, logic [7:0] mask);
        logic [NW*WW-1:0] l;
        for (int i = 0; i < NW; i++) l[i*WW +: WW] = mk_word(seed, i, mask[i]);
        return l;
    endfunction

    task automatic check(string tag, bit ok, string what, longint act, longint exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic redirect(int off);
        @(posedge clk); #1;
        redir_valid = 1'b1;
        redir_off   = PW'(off);
        @(posedge clk); #1;
        redir_valid = 1'b0;
    endtask

    task automatic send_lines(int n);
        @(posedge clk); #1;
        line_valid = 1'b1;
        for (int k = 0; k < n; k++) begin
            line_data = seq_data[k];
            line_addr = seq_addr[k];
            do @(negedge clk); while (!line_ready);
            @(posedge clk); #1;
        end
        line_valid = 1'b0;
    endtask

    // expected stream built from the requirements text
    task automatic build_exp(int n, int off);
        logic [7:0] inh;
        e_n = 0;
        inh = '0;
        for (int k = 0; k < n; k++) begin
            logic [7:0] fl;
            int p;
            for (int i = 0; i < NW; i++) fl[i] = seq_data[k][i*WW + WW - 1];
            p = (k == 0) ? off : 0;
            while (p < NW) begin
                bit wide;
                int np;
                wide = inh[p] && (p != NW - 1);
                np = p + (wide ? 2 : 1);
                e_data[e_n] = {seq_data[k][p*WW +: WW], wide ? seq_data[k][(p+1)*WW +: WW] : 32'h0};
                e_wide[e_n] = wide;
                e_addr[e_n] = {seq_addr[k], PW'(p)};
                e_err[e_n]  = (wide && inh[p+1]) || (np >= NW && fl[NW-1]);
                e_n++;
                p = np;
            end
            inh = fl & 8'h7F;
        end
    endtask

    task automatic compare(string tag);
        check(tag, g_n == e_n, "instruction count", g_n, e_n);
        for (int i = 0; i < e_n && i < g_n; i++) begin
            check(tag, g_data[i] == e_data[i], $sformatf("data #%0d", i), g_data[i], e_data[i]);
            check(tag, {g_wide[i], g_err[i]} == {e_wide[i], e_err[i]},
                  $sformatf("wide/err #%0d", i), {g_wide[i], g_err[i]}, {e_wide[i], e_err[i]});
            check(tag, g_addr[i] == e_addr[i], $sformatf("addr #%0d", i), g_addr[i], e_addr[i]);
        end
    endtask

    task automatic run_case(string tag, int n, int off);
        redirect(off);
        g_n = 0;
        send_lines(n);
        repeat (60) @(posedge clk);
        build_exp(n, off);
        compare(tag);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", ins_valid == 1'b0, "ins_valid in reset", ins_valid, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check("R1", ins_valid == 1'b0, "ins_valid after reset", ins_valid, 0);
        check("R1", line_ready == 1'b1, "line_ready after reset", line_ready, 1);
    endtask

    task automatic t_plain;
        seq_data[0] = mk_line(11, 8'h00); seq_addr[0] = 16'h0040;
        seq_data[1] = mk_line(12, 8'h00); seq_addr[1] = 16'h0041;
        run_case("R2", 2, 0);
        // R9: sixteen takes on consecutive cycles across the line change
        check("R9", g_n == 16 && g_cyc[15] - g_cyc[0] == 15, "cycle span of 16 takes",
              g_n == 16 ? g_cyc[15] - g_cyc[0] : -1, 15);
    endtask

    task automatic t_mixed(string tag, int mode);
        seq_data[0] = mk_line(21, 8'b0010_1001); seq_addr[0] = 16'h0100;
        seq_data[1] = mk_line(22, 8'b0000_0100); seq_addr[1] = 16'h0101;
        seq_data[2] = mk_line(23, 8'b0000_0000); seq_addr[2] = 16'h0102;
        stall_mode = mode;
        run_case(tag, 3, 0);
        stall_mode = 0;
        // R4: third line has one pair only (slot 2), so 7 instructions
        if (mode == 0)
            check("R4", g_n == 8 + 5 + 7, "total over three lines", g_n, 20);
    endtask

    task automatic t_top_flag;
        seq_data[0] = mk_line(31, 8'h80); seq_addr[0] = 16'h0200;
        seq_data[1] = mk_line(32, 8'hC0); seq_addr[1] = 16'h0201;
        seq_data[2] = mk_line(33, 8'h80); seq_addr[2] = 16'h0202;
        run_case("R5", 3, 0);
    endtask

    task automatic t_overlap;
        seq_data[0] = mk_line(41, 8'h0C); seq_addr[0] = 16'h0300;
        seq_data[1] = mk_line(42, 8'h00); seq_addr[1] = 16'h0301;
        run_case("R6", 2, 0);
    endtask

    task automatic t_redirect_target;
        // fully flagged line first; its flags must not reach the target line
        seq_data[0] = mk_line(51, 8'h7F); seq_addr[0] = 16'h0400;
        redirect(0);
        send_lines(1);
        repeat (20) @(posedge clk);
        seq_data[0] = mk_line(52, 8'h00); seq_addr[0] = 16'h0410;
        run_case("R7", 1, 5);
        check("R7", g_n == 3 && g_addr[0] == {16'h0410, 3'd5}, "first target address",
              g_n > 0 ? g_addr[0] : 0, {16'h0410, 3'd5});
    endtask

    task automatic t_flush_stalled;
        logic [63:0]      d0;
        logic [AW+PW-1:0] a0;
        redirect(0);
        stall_mode = 2;
        seq_data[0] = mk_line(61, 8'h00); seq_addr[0] = 16'h0500;
        send_lines(1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        d0 = ins_data; a0 = ins_addr;
        check("R8", ins_valid == 1'b1, "valid under stall", ins_valid, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", ins_valid && ins_data == d0 && ins_addr == a0, "held data under stall",
              ins_data, d0);
        seq_data[0] = mk_line(62, 8'h00); seq_addr[0] = 16'h0510;
        redirect(6);
        @(negedge clk);
        check("R7", ins_valid == 1'b0, "valid after flush", ins_valid, 0);
        stall_mode = 0;
        g_n = 0;
        send_lines(1);
        repeat (30) @(posedge clk);
        build_exp(1, 6);
        compare("R7");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_plain();
        t_mixed("R3", 0);
        t_mixed("R8", 1);
        t_top_flag();
        t_overlap();
        t_redirect_target();
        t_flush_stalled();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule